// File: doc/BRIEF.md
# ECC Fault Injection Controller

This block holds a software-written control word that arms deliberate data corruption on the write paths of eleven ECC-protected internal RAMs. Each RAM owns a 2-bit field in the word. When a field is armed and that RAM's write path next carries a valid write, the block computes the check bits from the clean data word. It then flips one or two data bits before the word leaves for the array. After that, the field returns to zero by itself. Software can therefore plant exactly one known single-bit or double-bit error per arming and exercise its error-handling code.

A small parity/Hamming-style encoder stub sits on every write path, so the stored check bits always describe the uncorrupted word. The corruption never touches check bits. For the translation buffer RAM, the flips land in the tag (virtual page number) part of the word, which starts at a parameterised bit offset. For every other RAM, the flips land at data bit 0.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: Field n occupies control-word bits [2n+1:2n], in this order from n=0: register file, instruction tag, instruction data, data tag, data-cache data, translation buffer, data tightly coupled memories 0 to 3, data-cache writeback. Bits 31:22 ignore writes and read as zero. `reg_rdata` always shows the current value of every field.
- R2: After reset, every field reads 00.
- R3: With a field at 01, a valid write on that RAM port flips data bit `LSB`. With a field at 10, it flips bits `LSB` and `LSB+1`. `LSB` is 0 for every RAM except the translation buffer.
- R4: Check bit k (k < CW-1) is the XOR of every data bit j for which bit k of (j+1) is set. The top check bit is the XOR of all data bits. Check bits are always taken from the uncorrupted input word.
- R5: An armed field (01 or 10) reads 00 from the clock edge that ends the cycle in which its RAM write was valid.
- R6: A field at 11 never corrupts data and keeps its value through writes.
- R7: A register write in the same cycle as a self-clear wins: the newly written value is kept.
- R8: Without a valid write, the data passes unchanged and an armed field stays armed.
- R9: For the translation buffer RAM (field 5), `LSB` equals parameter `TLB_TAG_LSB`.
- R10: Corrupted data and check bits appear on a port's outputs combinationally, in the same cycle as its write-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| ram_wr_valid | input | 11 | Per-RAM write valid |
| ram_wr_data | input | 11*DW | Per-RAM clean write data, RAM n in slice n |
| ram_out_data | output | 11*DW | Per-RAM data to the array, possibly corrupted |
| ram_out_check | output | 11*CW | Per-RAM check bits of the clean data |

## Verification
The bench aims first at the exact bit positions flipped for each RAM and each mode, including the translation buffer tag offset. A design that used the wrong offset or flipped check bits would produce the wrong data or check values. It then drives a register write onto the same edge as a self-clear. A design with the wrong priority would lose the new value and read 00. The value 11 and idle cycles with an armed field are probed: a design that acted on 11 or cleared early would show either corrupted data or a field that had already dropped to zero. Writing all ones shows whether the reserved bits stay zero.

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl #(
  parameter int DW          = 32,
  parameter int TLB_TAG_LSB = 12,
  parameter int CW          = $clog2(DW + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [10:0]        ram_wr_valid,
  input  logic [11*DW-1:0]   ram_wr_data,
  output logic [11*DW-1:0]   ram_out_data,
  output logic [11*CW-1:0]   ram_out_check
);
  localparam int NRAM    = 11;
  localparam int FW      = 2 * NRAM;
  localparam int TLB_IDX = 5;

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int k = 0; k < CW - 1; k++)
      for (int j = 0; j < DW; j++)
        if (((j + 1) >> k) & 1) c[k] = c[k] ^ d[j];
    c[CW-1] = ^d;
    return c;
  endfunction

  logic [FW-1:0]   inj_q;
  logic [NRAM-1:0] fire;

  assign reg_rdata = {{(32 - FW){1'b0}}, inj_q};

  for (genvar i = 0; i < NRAM; i++) begin : g_ram
    localparam int LSB = (i == TLB_IDX) ? TLB_TAG_LSB : 0;
    logic [1:0]    mode;
    logic [DW-1:0] flip;
    assign mode = inj_q[2*i +: 2];
    assign fire[i] = ram_wr_valid[i] && (mode == 2'b01 || mode == 2'b10);
    always_comb begin
      flip = '0;
      if (fire[i]) begin
        flip[LSB] = 1'b1;
        if (mode == 2'b10) flip[LSB + 1] = 1'b1;
      end
    end
    assign ram_out_data[i*DW +: DW]  = ram_wr_data[i*DW +: DW] ^ flip;
    assign ram_out_check[i*CW +: CW] = encode(ram_wr_data[i*DW +: DW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) inj_q <= '0;
    else if (reg_we) inj_q <= reg_wdata[FW-1:0];
    else
      for (int i = 0; i < NRAM; i++)
        if (fire[i]) inj_q[2*i +: 2] <= 2'b00;
  end
endmodule

// File: rtl/ecc_inject_ctrl_chk.sv
module ecc_inject_ctrl_chk #(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic [10:0]      ram_wr_valid,
  input logic [11*DW-1:0] ram_wr_data,
  input logic [11*DW-1:0] ram_out_data
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:22] == 10'd0);

  p_write_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[21:0] == $past(reg_wdata[21:0]));

  for (genvar i = 0; i < 11; i++) begin : g_chk
    p_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_wr_valid[i] && !reg_we &&
       (reg_rdata[2*i +: 2] == 2'b01 || reg_rdata[2*i +: 2] == 2'b10))
      |=> reg_rdata[2*i +: 2] == 2'b00);

    p_flip_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ram_out_data[i*DW +: DW] ^ ram_wr_data[i*DW +: DW]) <= 2);

    p_idle_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_wr_valid[i] |-> ram_out_data[i*DW +: DW] == ram_wr_data[i*DW +: DW]);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_wr_valid[i] && !reg_we) |=> $stable(reg_rdata[2*i +: 2]));

    p_code3_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[2*i +: 2] == 2'b11 |->
      ram_out_data[i*DW +: DW] == ram_wr_data[i*DW +: DW]);
  end
endmodule

bind ecc_inject_ctrl ecc_inject_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ram_wr_valid(ram_wr_valid),
  .ram_wr_data(ram_wr_data), .ram_out_data(ram_out_data)
);

// File: tb/ecc_inject_ctrl_test.sv
module ecc_inject_ctrl_test;
  localparam int DW = 32;
  localparam int TAG = 12;
  localparam int CW = $clog2(DW + 1) + 1;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             reg_we = 0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [10:0]      ram_wr_valid = '0;
  logic [11*DW-1:0] ram_wr_data = '0;
  logic [11*DW-1:0] ram_out_data;
  logic [11*CW-1:0] ram_out_check;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_inject_ctrl #(.DW(DW), .TLB_TAG_LSB(TAG)) uut (.*);

  // {ram index, mode, data, expected xor mask}
  localparam logic [69:0] VEC [10] = '{
    {4'd0,  2'b01, 32'hDEADBEEF, 32'h0000_0001},
    {4'd0,  2'b10, 32'h1234_5678, 32'h0000_0003},
    {4'd1,  2'b01, 32'h0000_0000, 32'h0000_0001},
    {4'd3,  2'b10, 32'hFFFF_FFFF, 32'h0000_0003},
    {4'd4,  2'b01, 32'hA5A5_A5A5, 32'h0000_0001},
    {4'd5,  2'b01, 32'h0F0F_0F0F, 32'h0000_1000},
    {4'd5,  2'b10, 32'h0F0F_0F0F, 32'h0000_3000},
    {4'd7,  2'b10, 32'h8000_0001, 32'h0000_0003},
    {4'd10, 2'b01, 32'h5555_AAAA, 32'h0000_0001},
    {4'd2,  2'b11, 32'hCAFE_F00D, 32'h0000_0000}
  };

  function automatic logic [CW-1:0] ref_check(input logic [DW-1:0] d);
    logic [CW-1:0] r = '0;
    for (int j = 0; j < DW; j++) begin
      for (int k = 0; k < CW - 1; k++)
        r[k] ^= d[j] & (((j + 1) >> k) & 1);
      r[CW-1] ^= d[j];
    end
    return r;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(reg_rdata, 0, "R2 reset state");

    for (int v = 0; v < 10; v++) begin
      int idx; logic [1:0] md; logic [31:0] d, m;
      {idx, md, d, m} = {VEC[v][69:66], VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]};
      wr_reg(32'(md) << (2 * idx));
      check(reg_rdata[2*idx +: 2], md, "R1 readback");
      @(negedge clk);
      ram_wr_data[idx*DW +: DW] = d; ram_wr_valid[idx] = 1;
      #2;
      check(ram_out_data[idx*DW +: DW], d ^ m, "R3/R9/R6/R10 corrupted data");
      check(ram_out_check[idx*CW +: CW], ref_check(d), "R4 check bits");
      @(negedge clk); ram_wr_valid = '0;
      check(reg_rdata[2*idx +: 2], (md == 2'b11) ? 2'b11 : 2'b00, "R5/R6 field after write");
    end

    wr_reg(32'hFFFF_FFFF);
    check(reg_rdata, 32'h003F_FFFF, "R1 reserved bits zero");
    wr_reg(0);

    // R8: armed field holds and data passes while idle
    wr_reg(32'h0000_0100);
    ram_wr_data[4*DW +: DW] = 32'h1357_9BDF;
    repeat (4) @(negedge clk);
    check(ram_out_data[4*DW +: DW], 32'h1357_9BDF, "R8 idle pass");
    check(reg_rdata[9:8], 2'b01, "R8 armed held");
    // other RAM's write must not disturb field 4
    @(negedge clk); ram_wr_valid[0] = 1;
    @(negedge clk); ram_wr_valid = '0;
    check(reg_rdata[9:8], 2'b01, "R8 other port leaves field");

    // R7: register write on the self-clear edge
    wr_reg(32'h0000_0001);
    @(negedge clk);
    ram_wr_data[0 +: DW] = 32'h0000_00F0; ram_wr_valid[0] = 1;
    reg_we = 1; reg_wdata = 32'h0000_0002;
    #2;
    check(ram_out_data[0 +: DW], 32'h0000_00F1, "R7 old mode used this cycle");
    @(negedge clk); reg_we = 0; ram_wr_valid = '0;
    check(reg_rdata[1:0], 2'b10, "R7 write wins over clear");

    // R9: TLB double flip at tag offset, low bits untouched
    wr_reg(32'h0000_0800);
    @(negedge clk);
    ram_wr_data[5*DW +: DW] = 32'h0000_0000; ram_wr_valid[5] = 1;
    #2;
    check(ram_out_data[5*DW +: DW], 32'h0000_3000, "R9 tag offset");
    @(negedge clk); ram_wr_valid = '0;

    // R2: reset clears armed fields
    wr_reg(32'h002A_AAAA);
    rst_n = 0; @(negedge clk); rst_n = 1; #2;
    check(reg_rdata, 0, "R2 reset clears");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule